// File: doc/BRIEF.md
# Multi-cycle accumulator processor core

This block is a small 8-bit processor built around one accumulator. One 32-byte memory holds both program and data. A control sequencer moves every value through a memory address register and a memory data register, doing one register transfer per clock. Each instruction takes four steps to fetch and decode it, followed by a short execute sequence that depends on the opcode. Branch decisions look at the accumulator value directly, so the core has no condition flags.

Before a run, a testbench or loader fills the memory through a valid/ready write port. A write takes effect on a rising clock edge only when `pl_valid` and `pl_ready` are both high. `pl_ready` is high only while reset is asserted or the core has halted. When `pl_ready` is low, an offered write is not held back and is not queued: it is dropped, and the loader has to keep `pl_valid` asserted until it sees ready. While reset is held, the program counter loads from `start_addr`. When reset is released, execution starts at that address and continues until a halt instruction is reached. A combinational peek port shows any memory byte at any time.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, the PC takes `start_addr`, the accumulator becomes 0 and `halted` becomes 0.
- R2: `pl_ready` equals `rst` OR `halted`. On an edge where `pl_valid` and `pl_ready` are both high, `pl_data` is written to `pl_addr`. A write offered while `pl_ready` is low leaves memory unchanged.
- R3: An instruction byte holds the opcode in bits [7:5] and the address in bits [4:0]. Opcode 0 is halt, 1 load, 2 store, 3 add, 4 subtract, 5 branch, 6 branch-if-zero, 7 branch-if-positive.
- R4: Fetch and decode take 4 cycles. Load, store, add and subtract take 8 cycles in total, and the PC changes on the 8th. A branch takes 5 cycles, and the PC changes on the 5th. The PC holds its value in every other cycle.
- R5: Load puts the addressed memory byte into the accumulator on cycle 7 of the instruction.
- R6: Add sets the accumulator to (acc + mem) mod 256. For example, 5 + 0xFD gives 2.
- R7: Subtract sets the accumulator to (acc - mem) mod 256. For example, 0 - 1 gives 0xFF.
- R8: Store writes the accumulator to the addressed byte and leaves the accumulator unchanged.
- R9: Branch always loads the PC with the address field. Branch-if-zero does so only when acc = 0. Branch-if-positive does so only when acc[7] = 0 and acc is not 0. When a conditional branch is not taken, the PC increments.
- R10: A PC increment from 31 wraps to 0.
- R11: A halt is fetched and decoded like any other instruction, and then `halted` rises. From then on, the PC and accumulator stay constant until reset.
- R12: `peek_data` always equals the memory byte at `peek_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_addr | input | 5 | PC value loaded while in reset |
| pl_valid | input | 1 | Preload write offered |
| pl_ready | output | 1 | Preload write accepted this edge |
| pl_addr | input | 5 | Preload write address |
| pl_data | input | 8 | Preload write byte |
| peek_addr | input | 5 | Memory byte to observe |
| peek_data | output | 8 | Memory byte at peek_addr |
| halted | output | 1 | Core has executed a halt |
| pc_o | output | 5 | Program counter |
| acc_o | output | 8 | Accumulator |

## Verification
The cases hardest to reach are the PC wrap and the two not-taken conditional branches, because they need a whole program to lead the PC and the accumulator into the right state. One image starts at address 30 and runs across the wrap into a taken positive branch. A countdown loop drives the accumulator through zero and then negative, which exercises both outcomes of each conditional branch. The bench also offers a preload write in the middle of the run, to show that a write refused while busy never reaches memory.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [2:0] {
    OP_HLT = 3'd0,
    OP_LDA = 3'd1,
    OP_STA = 3'd2,
    OP_ADD = 3'd3,
    OP_SUB = 3'd4,
    OP_BR  = 3'd5,
    OP_BRZ = 3'd6,
    OP_BRP = 3'd7
  } opcode_e;

  typedef enum logic [3:0] {
    ST_FADR, ST_FRD, ST_FIR, ST_DEC,
    ST_OADR, ST_ORD, ST_EXE,
    ST_SDAT, ST_SADR, ST_SWR,
    ST_INC, ST_BR, ST_HALT
  } phase_e;

  typedef enum logic [1:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB
  } aluop_e;

  typedef struct packed {
    logic   mar_from_pc;
    logic   mar_from_ir;
    logic   mdr_from_mem;
    logic   mdr_from_acc;
    logic   ir_load;
    logic   acc_load;
    logic   pc_inc;
    logic   pc_branch;
    logic   mem_we;
    aluop_e aluop;
  } ctl_s;

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [DATA_W-1:0] peek_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[waddr] <= wdata;
  end

  assign rdata     = store_q[raddr];
  assign peek_data = store_q[peek_addr];
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluop_e            aluop,
  input  opcode_e           op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] result,
  output logic              take
);
  logic acc_zero;
  logic acc_neg;

  assign acc_zero = (acc == '0);
  assign acc_neg  = acc[DATA_W-1];

  always_comb begin
    unique case (aluop)
      ALU_ADD: result = acc + opnd;
      ALU_SUB: result = acc - opnd;
      default: result = opnd;
    endcase
  end

  always_comb begin
    unique case (op)
      OP_BR:   take = 1'b1;
      OP_BRZ:  take = acc_zero;
      OP_BRP:  take = !acc_neg && !acc_zero;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  opcode_e op,
  input  logic    take,
  output ctl_s    ctl,
  output phase_e  phase,
  output logic    halted
);
  phase_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_FADR;
    else     state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FADR: state_d = ST_FRD;
      ST_FRD:  state_d = ST_FIR;
      ST_FIR:  state_d = ST_DEC;
      ST_DEC: begin
        unique case (op)
          OP_HLT:                 state_d = ST_HALT;
          OP_LDA, OP_ADD, OP_SUB: state_d = ST_OADR;
          OP_STA:                 state_d = ST_SDAT;
          default:                state_d = ST_BR;
        endcase
      end
      ST_OADR: state_d = ST_ORD;
      ST_ORD:  state_d = ST_EXE;
      ST_EXE:  state_d = ST_INC;
      ST_SDAT: state_d = ST_SADR;
      ST_SADR: state_d = ST_SWR;
      ST_SWR:  state_d = ST_INC;
      ST_INC:  state_d = ST_FADR;
      ST_BR:   state_d = ST_FADR;
      default: state_d = ST_HALT;
    endcase
  end

  always_comb begin
    ctl = '0;
    unique case (state_q)
      ST_FADR: ctl.mar_from_pc  = 1'b1;
      ST_FRD:  ctl.mdr_from_mem = 1'b1;
      ST_FIR:  ctl.ir_load      = 1'b1;
      ST_OADR: ctl.mar_from_ir  = 1'b1;
      ST_ORD:  ctl.mdr_from_mem = 1'b1;
      ST_EXE: begin
        ctl.acc_load = 1'b1;
        unique case (op)
          OP_ADD:  ctl.aluop = ALU_ADD;
          OP_SUB:  ctl.aluop = ALU_SUB;
          default: ctl.aluop = ALU_PASS;
        endcase
      end
      ST_SDAT: ctl.mdr_from_acc = 1'b1;
      ST_SADR: ctl.mar_from_ir  = 1'b1;
      ST_SWR:  ctl.mem_we       = 1'b1;
      ST_INC:  ctl.pc_inc       = 1'b1;
      ST_BR: begin
        ctl.pc_branch = take;
        ctl.pc_inc    = !take;
      end
      default: ;
    endcase
  end

  assign phase  = state_q;
  assign halted = (state_q == ST_HALT);

  // R4: fetch order is fixed, each fetch step leads to the next one
  a_r4_fetch_order: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FADR) |=> (state_q == ST_FRD));
endmodule

// File: rtl/acc_cpu_dpath.sv
module acc_cpu_dpath
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] start_addr,
  input  ctl_s              ctl,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] alu_res,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ir,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mdr,
  output logic [DATA_W-1:0] acc
);
  logic [ADDR_W-1:0] ir_addr;
  assign ir_addr = ir[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= start_addr;
      ir  <= '0;
      mar <= '0;
      mdr <= '0;
      acc <= '0;
    end else begin
      if (ctl.pc_branch)        pc  <= ir_addr;
      else if (ctl.pc_inc)      pc  <= pc + 1'b1;
      if (ctl.ir_load)          ir  <= mdr;
      if (ctl.mar_from_pc)      mar <= pc;
      else if (ctl.mar_from_ir) mar <= ir_addr;
      if (ctl.mdr_from_mem)     mdr <= mem_rdata;
      else if (ctl.mdr_from_acc) mdr <= acc;
      if (ctl.acc_load)         acc <= alu_res;
    end
  end

  // R5: a load step leaves the accumulator equal to the byte in MDR
  a_r5_load_copies: assert property (@(posedge clk) disable iff (rst)
    (ctl.acc_load && ctl.aluop == ALU_PASS) |=> (acc == $past(mdr)));
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              pl_valid,
  output logic              pl_ready,
  input  logic [ADDR_W-1:0] pl_addr,
  input  logic [DATA_W-1:0] pl_data,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [DATA_W-1:0] peek_data,
  output logic              halted,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o
);
  localparam int OP_W = DATA_W - ADDR_W;

  ctl_s              ctl;
  phase_e            phase;
  logic [DATA_W-1:0] ir, mdr, acc, alu_res, mem_rdata;
  logic [ADDR_W-1:0] pc, mar;
  logic              take;
  opcode_e           op;
  logic              pl_fire;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;

  assign op       = opcode_e'(ir[DATA_W-1 -: OP_W]);
  assign pl_ready = rst || halted;
  assign pl_fire  = pl_valid && pl_ready;

  assign mem_we    = ctl.mem_we || pl_fire;
  assign mem_waddr = pl_fire ? pl_addr : mar;
  assign mem_wdata = pl_fire ? pl_data : mdr;

  acc_cpu_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk       (clk),
    .we        (mem_we),
    .waddr     (mem_waddr),
    .wdata     (mem_wdata),
    .raddr     (mar),
    .rdata     (mem_rdata),
    .peek_addr (peek_addr),
    .peek_data (peek_data)
  );

  acc_cpu_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .take   (take),
    .ctl    (ctl),
    .phase  (phase),
    .halted (halted)
  );

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .aluop  (ctl.aluop),
    .op     (op),
    .acc    (acc),
    .opnd   (mdr),
    .result (alu_res),
    .take   (take)
  );

  acc_cpu_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .start_addr (start_addr),
    .ctl        (ctl),
    .mem_rdata  (mem_rdata),
    .alu_res    (alu_res),
    .pc         (pc),
    .ir         (ir),
    .mar        (mar),
    .mdr        (mdr),
    .acc        (acc)
  );

  assign pc_o  = pc;
  assign acc_o = acc;

  // R1: reset loads the start address and clears state
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pc_o == $past(start_addr) && !halted && acc_o == '0));

  // R4: PC only moves on the last step of an instruction
  a_r4_pc_holds_mid_instr: assert property (@(posedge clk) disable iff (rst)
    (phase != ST_INC && phase != ST_BR) |=> $stable(pc_o));

  // R10: increment from the top address wraps to zero
  a_r10_pc_wraps: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_INC && pc_o == '1) |=> (pc_o == '0));

  // R8: the store sequence never touches the accumulator
  a_r8_store_keeps_acc: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_SDAT || phase == ST_SADR || phase == ST_SWR) |=> $stable(acc_o));

  // R11: once halted, PC and accumulator freeze
  a_r11_halt_freezes: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc_o) && $stable(acc_o)));

  // R2: the core never writes memory in a cycle a preload is accepted
  a_r2_single_writer: assert property (@(posedge clk) disable iff (rst)
    ctl.mem_we |-> !pl_fire);
endmodule

// File: tb/acc_cpu_tb_top.sv
`timescale 1ns/1ps
module acc_cpu_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] start_addr = '0;
  logic       pl_valid = 1'b0;
  logic       pl_ready;
  logic [4:0] pl_addr = '0;
  logic [7:0] pl_data = '0;
  logic [4:0] peek_addr = '0;
  logic [7:0] peek_data;
  logic       halted;
  logic [4:0] pc_o;
  logic [7:0] acc_o;

  always #2.5 clk = ~clk;

  acc_cpu dut_i (
    .clk(clk), .rst(rst), .start_addr(start_addr),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_addr(pl_addr), .pl_data(pl_data),
    .peek_addr(peek_addr), .peek_data(peek_data),
    .halted(halted), .pc_o(pc_o), .acc_o(acc_o)
  );

  int nvec  = 0;
  int nfail = 0;
  logic cmp_en = 1'b0;
  logic [7:0] img [32];

  // behavioural reference model, advanced on every rising edge
  logic [7:0] mmem [32];
  logic [4:0] m_pc = '0;
  logic [7:0] m_acc = '0;
  logic       m_halt = 1'b0;
  int         k = 0;
  logic [2:0] m_op = '0;
  logic [4:0] m_a = '0;

  initial for (int i = 0; i < 32; i++) mmem[i] = 8'h00;

  always @(posedge clk) begin
    int nk;
    logic tk;
    if (pl_valid && (rst || m_halt)) mmem[pl_addr] = pl_data;
    if (rst) begin
      m_pc = start_addr; m_acc = 8'h00; m_halt = 1'b0; k = 0;
    end else if (!m_halt) begin
      if (k == 0) begin m_op = mmem[m_pc][7:5]; m_a = mmem[m_pc][4:0]; end
      nk = k + 1;
      if (k == 3 && m_op == 3'd0) m_halt = 1'b1;
      if (k == 4 && m_op >= 3'd5) begin
        tk = (m_op == 3'd5) || (m_op == 3'd6 && m_acc == 8'h00) ||
             (m_op == 3'd7 && !m_acc[7] && m_acc != 8'h00);
        m_pc = tk ? m_a : m_pc + 5'd1;
        nk = 0;
      end
      if (k == 6) begin
        case (m_op)
          3'd1: m_acc = mmem[m_a];
          3'd2: mmem[m_a] = m_acc;
          3'd3: m_acc = m_acc + mmem[m_a];
          3'd4: m_acc = m_acc - mmem[m_a];
          default: ;
        endcase
      end
      if (k == 7) begin m_pc = m_pc + 5'd1; nk = 0; end
      k = nk;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (cmp_en) begin
      chk("R4/R9/R10 pc", {3'b0, pc_o}, {3'b0, m_pc});
      chk("R5/R6/R7 acc", acc_o, m_acc);
      chk("R11 halted", {7'b0, halted}, {7'b0, m_halt});
      chk("R2 pl_ready", {7'b0, pl_ready}, {7'b0, (rst || m_halt)});
      chk("R12 peek", peek_data, mmem[peek_addr]);
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    #1000000;
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic clear_img();
    for (int i = 0; i < 32; i++) img[i] = 8'h00;
  endtask

  // hold reset, preload the whole image, release reset
  task automatic boot(input logic [4:0] s);
    @(negedge clk);
    rst = 1'b1; start_addr = s; pl_valid = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      pl_valid = 1'b1; pl_addr = 5'(i); pl_data = img[i];
      @(negedge clk);
    end
    pl_valid = 1'b0;
    cmp_en = 1'b1;
    #1;
    chk("R1 reset pc", {3'b0, pc_o}, {3'b0, s});
    chk("R1 reset acc", acc_o, 8'h00);
    chk("R1 reset halted", {7'b0, halted}, 8'h00);
    chk("R2 ready in reset", {7'b0, pl_ready}, 8'h01);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_to_halt(input int prog, output int cycles);
    int cyc = 0;
    while (!halted && cyc < 3000) begin
      @(negedge clk);
      peek_addr = 5'(cyc);
      pl_valid = 1'b0;
      if (prog == 2 && cyc == 3) begin
        pl_valid = 1'b1; pl_addr = 5'd25; pl_data = 8'hAA;
      end
      #1;
      cyc++;
      if (prog == 0 && cyc == 7) chk("R5 load result", acc_o, 8'h05);
      if (prog == 2 && cyc == 4) chk("R2 ready low while running", {7'b0, pl_ready}, 8'h00);
    end
    pl_valid = 1'b0;
    cycles = cyc;
  endtask

  task automatic peek_chk(input string tag, input logic [4:0] a, input logic [7:0] exp);
    @(negedge clk);
    peek_addr = a;
    #1;
    chk(tag, peek_data, exp);
  endtask

  initial begin
    int cyc;
    logic [4:0] pc_snap;
    logic [7:0] acc_snap;

    // Program A (R3 encodings): load +5, add -3, store to 10, halt at 7
    clear_img();
    img[4] = 8'h28; img[5] = 8'h69; img[6] = 8'h4A; img[7] = 8'h00;
    img[8] = 8'h05; img[9] = 8'hFD;
    boot(5'd4);
    run_to_halt(0, cyc);
    chk("R4 cycles to halt", 8'(cyc), 8'd28);
    chk("R11 halt pc", {3'b0, pc_o}, 8'h07);
    chk("R6 acc after add", acc_o, 8'h02);
    peek_chk("R6 R8 stored sum", 5'd10, 8'h02);
    pc_snap = pc_o; acc_snap = acc_o;
    repeat (10) @(negedge clk);
    #1;
    chk("R11 pc frozen", {3'b0, pc_o}, {3'b0, pc_snap});
    chk("R11 acc frozen", acc_o, acc_snap);
    // R2: preload accepted while halted
    @(negedge clk);
    pl_valid = 1'b1; pl_addr = 5'd26; pl_data = 8'h5A;
    @(negedge clk);
    pl_valid = 1'b0;
    peek_chk("R2 write while halted", 5'd26, 8'h5A);

    // Program B: countdown loop, subtract through zero to negative
    clear_img();
    img[0] = 8'h34; img[1] = 8'h95; img[2] = 8'hC4; img[3] = 8'hA1;
    img[4] = 8'h95; img[5] = 8'hFF; img[6] = 8'h56; img[7] = 8'h00;
    img[20] = 8'h03; img[21] = 8'h01;
    boot(5'd0);
    run_to_halt(1, cyc);
    chk("R9 halt pc after loop", {3'b0, pc_o}, 8'h07);
    chk("R7 acc wraps negative", acc_o, 8'hFF);
    peek_chk("R7 R8 stored diff", 5'd22, 8'hFF);

    // Program C: start at 30, wrap past 31, taken positive branch
    clear_img();
    img[30] = 8'h3C; img[31] = 8'h7D; img[0] = 8'hE3; img[1] = 8'h00;
    img[3] = 8'h5B; img[4] = 8'h00;
    img[28] = 8'h40; img[29] = 8'h01;
    boot(5'd30);
    run_to_halt(2, cyc);
    chk("R10 R9 halt pc", {3'b0, pc_o}, 8'h04);
    peek_chk("R9 stored after branch", 5'd27, 8'h41);
    peek_chk("R2 busy write ignored", 5'd25, 8'h00);
    peek_chk("R12 peek untouched", 5'd1, 8'h00);

    finish_run();
  end
endmodule